// File: doc/BRIEF.md
# Disk-Change Flag Latch

This block keeps the sticky "media may have changed" flag for a single drive. A drive controller shows it as the top bit of a status byte that software reads. The flag starts set. Ejecting the media sets it again. Only one event clears it: a real head step while media sits in the drive. Reading the flag leaves it unchanged. Inserting media or idling the positioner also leaves it unchanged.

The block takes three inputs from the drive side: a media-present level, a one-cycle eject event, and the step signal from the head positioner. A seek to the cylinder the head already occupies issues no step, so such a seek leaves the flag as it was. A parameter chooses how the step signal is read. It is either a strobe that counts on every high cycle, or a level whose rising edge counts as one step. A read strobe loads a registered status byte. The flag sits at a parameterised bit position and every other bit reads as zero.

Top module: `media_change_latch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `chg_flag` is 1 and `rd_data` is 0x00.
- R2: A read (`rd_en` high) loads `rd_data` on the next clock edge with the flag in bit 7 (0x80 when set, 0x00 when clear). All other bits are zero. `rd_data` holds between reads, and no number of reads changes `chg_flag`.
- R3: A rising `media_present` alone does not clear the flag.
- R4: Cycles with no step event leave the flag unchanged. This covers a seek to the current cylinder, which issues no step.
- R5: A step event while `media_present` is 1 and `eject_evt` is 0 clears `chg_flag` on the following clock edge.
- R6: A step event while `media_present` is 0 leaves the flag set.
- R7: `eject_evt` sets `chg_flag` on the following edge. When it coincides with a step, the eject wins and the flag stays set.
- R8: In the default level mode, `step_in` held high for several cycles counts as a single step on its rising edge. Holding it high after an eject does not clear the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| media_present | input | 1 | 1 while media is in the drive |
| eject_evt | input | 1 | One-cycle eject event |
| step_in | input | 1 | Step signal from the head positioner |
| rd_en | input | 1 | Status read strobe |
| rd_data | output | 8 | Registered status byte, flag at bit 7 |
| chg_flag | output | 1 | Current flag value |

## Verification
The assertions check the following on every cycle:
- the reset value;
- that an eject sets the flag;
- that a step with media present clears it;
- that the flag falls only after such a step;
- that a held step level yields one event;
- that the read byte mirrors the flag seen at the read.

Only the bench scenarios can show whole behaviours over time:
- the insert-then-wait sequence leaving the flag set;
- the eject-and-step collision;
- a long held step surviving an eject.

Constrained random mixes of reads, steps, ejects and media changes are compared cycle by cycle with a bench model.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
   typedef enum logic [0:0] {
      STEP_STROBE = 1'b0,
      STEP_LEVEL  = 1'b1
   } step_mode_e;
endpackage

// File: rtl/mcl_step_detect.sv
module mcl_step_detect #(
   parameter mcl_pkg::step_mode_e MODE = mcl_pkg::STEP_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_in,
   output logic step_evt
);
   generate
      if (MODE == mcl_pkg::STEP_STROBE) begin : g_strobe
         assign step_evt = step_in;
      end else begin : g_level
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= step_in;
         end
         assign step_evt = step_in & ~prev_q;

         // R8: a held level produces exactly one event
         p_single_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
            step_evt && step_in |=> !step_evt)
            else $error("p_single_event_r8");
      end
   endgenerate
endmodule

// File: rtl/mcl_flag_reg.sv
module mcl_flag_reg #(
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_evt,
   input  logic media_present,
   input  logic eject_evt,
   output logic flag_q
);
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (eject_evt)                      flag_d = 1'b1;
      else if (step_evt && media_present) flag_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= RESET_VAL;
      else        flag_q <= flag_d;
   end

   // R1: reset forces the flag set
   p_reset_set_r1: assert property (@(posedge clk) !rst_n |=> flag_q)
      else $error("p_reset_set_r1");
   // R7: an eject sets the flag
   p_eject_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eject_evt |=> flag_q)
      else $error("p_eject_sets_r7");
   // R5: a step with media clears the flag
   p_step_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step_evt && media_present && !eject_evt |=> !flag_q)
      else $error("p_step_clears_r5");
   // R3 R4 R6: the flag falls only after a step with media
   p_fall_only_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !(step_evt && media_present) |=> flag_q)
      else $error("p_fall_only_step_r4");
endmodule

// File: rtl/mcl_read_port.sv
module mcl_read_port #(
   parameter int DATA_W   = 8,
   parameter int FLAG_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              flag,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

   generate
      if (FLAG_BIT < 0 || FLAG_BIT >= DATA_W) begin : g_bad_bit
         $error("FLAG_BIT outside DATA_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= flag ? FLAG_MASK : '0;
   end

   // R2: the byte mirrors the flag at the read; no other bit is set
   p_read_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rd_data[FLAG_BIT] == $past(flag)) && ((rd_data & ~FLAG_MASK) == '0))
      else $error("p_read_mirror_r2");
   p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data))
      else $error("p_read_hold_r2");
endmodule

// File: rtl/media_change_latch.sv
module media_change_latch #(
   parameter mcl_pkg::step_mode_e STEP_MODE = mcl_pkg::STEP_LEVEL,
   parameter int                  DATA_W    = 8,
   parameter int                  FLAG_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              media_present,
   input  logic              eject_evt,
   input  logic              step_in,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              chg_flag
);
   logic step_evt;

   mcl_step_detect #(.MODE(STEP_MODE)) u_step (
      .clk(clk), .rst_n(rst_n), .step_in(step_in), .step_evt(step_evt)
   );

   mcl_flag_reg #(.RESET_VAL(1'b1)) u_flag (
      .clk(clk), .rst_n(rst_n), .step_evt(step_evt),
      .media_present(media_present), .eject_evt(eject_evt), .flag_q(chg_flag)
   );

   mcl_read_port #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .flag(chg_flag), .rd_data(rd_data)
   );
endmodule

// File: tb/media_change_latch_tb.sv
module media_change_latch_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       media_present = 1'b0;
   logic       eject_evt = 1'b0;
   logic       step_in = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       chg_flag;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic       m_flag = 1'b1;
   logic       m_prev = 1'b0;
   logic [7:0] m_rd = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   media_change_latch u_dut (
      .clk(clk), .rst_n(rst_n), .media_present(media_present),
      .eject_evt(eject_evt), .step_in(step_in), .rd_en(rd_en),
      .rd_data(rd_data), .chg_flag(chg_flag)
   );

   function automatic logic next_flag(logic f, logic stp, logic med, logic ej);
      if (ej) return 1'b1;
      if (stp && med) return 1'b0;
      return f;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(string req);
      logic stp;
      @(posedge clk);
      stp = step_in & ~m_prev;
      if (rd_en) m_rd = m_flag ? 8'h80 : 8'h00;
      m_flag = next_flag(m_flag, stp, media_present, eject_evt);
      m_prev = step_in;
      @(negedge clk);
      check(req, {7'b0, chg_flag}, {7'b0, m_flag});
      check("R2", rd_data, m_rd);
   endtask

   task automatic drive(logic med, logic ej, logic stp, logic rd);
      media_present = med; eject_evt = ej; step_in = stp; rd_en = rd;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int unsigned seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R1", {7'b0, chg_flag}, 8'h01);
      check("R1", rd_data, 8'h00);
      rst_n = 1'b1;
      drive(0, 0, 0, 0); tick("R1");
      // R2 repeated reads with no media
      drive(0, 0, 0, 1); tick("R2"); tick("R2"); tick("R2");
      check("R2", rd_data, 8'h80);
      // R6 step without media
      drive(0, 0, 1, 0); tick("R6");
      drive(0, 0, 0, 0); tick("R6");
      // R3 insert media
      drive(1, 0, 0, 0); tick("R3"); tick("R3");
      // R4 seek to same cylinder: no step
      repeat (4) tick("R4");
      check("R4", {7'b0, chg_flag}, 8'h01);
      // R5 step with media
      drive(1, 0, 1, 0); tick("R5");
      check("R5", {7'b0, chg_flag}, 8'h00);
      drive(1, 0, 0, 1); tick("R2"); tick("R2");
      check("R2", rd_data, 8'h00);
      // R7 eject, then R6 steps without media
      drive(0, 1, 0, 0); tick("R7");
      check("R7", {7'b0, chg_flag}, 8'h01);
      drive(0, 0, 1, 0); tick("R6");
      drive(0, 0, 0, 0); tick("R6");
      // R7 eject and step in the same cycle
      drive(1, 0, 0, 0); tick("R3");
      drive(1, 1, 1, 0); tick("R7");
      check("R7", {7'b0, chg_flag}, 8'h01);
      drive(1, 0, 0, 0); tick("R7");
      // R8 held step level
      drive(1, 0, 1, 0); tick("R8");
      check("R8", {7'b0, chg_flag}, 8'h00);
      drive(1, 1, 1, 0); tick("R8");
      drive(1, 0, 1, 0); tick("R8"); tick("R8"); tick("R8");
      check("R8", {7'b0, chg_flag}, 8'h01);
      drive(1, 0, 0, 0); tick("R8");
      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic med, ej, stp, rd;
         med = ($urandom % 8) != 0;
         ej  = ($urandom % 16) == 0;
         stp = ($urandom % 3) == 0;
         rd  = ($urandom % 2) == 0;
         drive(med, ej, stp, rd);
         tick("R5");
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule